// File: doc/BRIEF.md
# PWM H-Bridge Motor Driver

This block turns a small register set into the two leg drive levels of a DC motor H-bridge. A host writes a period and an on-time, both counted in system clocks, and a configuration word. A free-running counter splits each PWM cycle into an on-phase and an off-phase. The configuration word sets the motor command for the on-phase and the leg pattern used during the off-phase. It can also exchange the two legs, invert either output, and gate the drive separately to an internal and an external bridge.

The programming port is a single-cycle write strobe with a two-bit word address. Reads are combinational on the same address. Period and on-time changes are held back until the next cycle boundary, so a running waveform never shows a runt pulse. A status word reports the live phase of the counter.

Top module: `motor_pwm_bridge`

## Requirements
- R1: After reset the period, on-time and configuration registers read zero, the status reads zero and all four bridge outputs are low.
- R2: Word addresses are 0 = period, 1 = on-time, 2 = configuration and 3 = status. Period and on-time read back as their low CNT_W bits, zero-extended. The configuration word keeps only bits 0, 16, 17, 18, 20, 21, 24, 25, 26 and 27, and all other bits read zero. A write to address 3 has no effect.
- R3: With configuration bit 0 set, the counter steps 0, 1, ... up to the active period value and then returns to 0, so one cycle lasts period+1 clocks. The on-phase holds while the count is below the active on-time. With bit 0 clear, the count rests at 0 and the on-phase is low.
- R4: A newly written period or on-time takes effect only when the counter returns to 0, or at once while generation is disabled.
- R5: Configuration bits 21:20 give the motor command as a leg pair (output 1, output 2): 00 coast (0,0), 01 forward (1,0), 10 backward (0,1), 11 brake (1,1).
- R6: In PWM mode (bit 18 clear), the command pattern drives the legs during the on-phase. During the off-phase the legs take the dwell pattern: brake (1,1) when bit 25 is 0, coast (0,0) when bit 25 is 1.
- R7: In direction mode (bit 18 set), the command pattern drives the legs on every cycle, whatever the phase.
- R8: With bit 0 clear, the legs are coast (0,0) before the swap and invert stages, whatever the other bits hold.
- R9: Bit 24 exchanges leg 1 and leg 2.
- R10: Bit 26 inverts output 1 and bit 27 inverts output 2. Inversion is applied after the swap.
- R11: Bit 16 passes the outputs to the internal pair (int_h1, int_h2) and bit 17 to the external pair (ext_h1, ext_h2). A pair whose bit is clear is held low.
- R12: Status bit 0 equals the current on-phase level, and all other status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_addr | input | 2 | Word address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| int_h1 | output | 1 | Internal bridge, output 1 |
| int_h2 | output | 1 | Internal bridge, output 2 |
| ext_h1 | output | 1 | External bridge, output 1 |
| ext_h2 | output | 1 | External bridge, output 2 |

## Verification
Several properties are checked on every cycle:
- the counter never passes the active period and returns to zero after reaching it;
- the active period and on-time stay frozen between cycle boundaries;
- a disabled bridge pair stays low, and a disabled generator leaves only the inversion pattern on the outputs;
- the status word read back matches the on-phase.

Only the bench scenarios can show the following:
- the exact waveform shape for a given period and on-time;
- the point at which a mid-cycle on-time change first appears;
- the mapping of each command, dwell, swap and invert setting to leg levels;
- the masking applied to register readback.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    A_PERIOD = 2'd0,
    A_ONTIME = 2'd1,
    A_CONFIG = 2'd2,
    A_STATUS = 2'd3
  } mpb_addr_e;

  localparam int B_EN     = 0;
  localparam int B_INT    = 16;
  localparam int B_EXT    = 17;
  localparam int B_DIR    = 18;
  localparam int B_CMD_LO = 20;
  localparam int B_SWAP   = 24;
  localparam int B_DWELL  = 25;
  localparam int B_INV1   = 26;
  localparam int B_INV2   = 27;

  typedef struct packed {
    logic       en;
    logic       int_on;
    logic       ext_on;
    logic       dir_mode;
    logic [1:0] cmd;
    logic       swap;
    logic       dwell_coast;
    logic       inv1;
    logic       inv2;
  } mpb_cfg_t;

  function automatic mpb_cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
    mpb_cfg_t c;
    c.en          = w[B_EN];
    c.int_on      = w[B_INT];
    c.ext_on      = w[B_EXT];
    c.dir_mode    = w[B_DIR];
    c.cmd         = w[B_CMD_LO+1:B_CMD_LO];
    c.swap        = w[B_SWAP];
    c.dwell_coast = w[B_DWELL];
    c.inv1        = w[B_INV1];
    c.inv2        = w[B_INV2];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_pack(input mpb_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_EN]                = c.en;
    w[B_INT]               = c.int_on;
    w[B_EXT]               = c.ext_on;
    w[B_DIR]               = c.dir_mode;
    w[B_CMD_LO+1:B_CMD_LO] = c.cmd;
    w[B_SWAP]              = c.swap;
    w[B_DWELL]             = c.dwell_coast;
    w[B_INV1]              = c.inv1;
    w[B_INV2]              = c.inv2;
    return w;
  endfunction

  // Leg pair: bit 0 = output 1, bit 1 = output 2.
  function automatic logic [1:0] phase_legs(input mpb_cfg_t c, input logic on_phase);
    if (!c.en)                       return 2'b00;
    else if (c.dir_mode || on_phase) return c.cmd;
    else if (c.dwell_coast)          return 2'b00;
    else                             return 2'b11;
  endfunction
endpackage

// File: rtl/mpb_regs.sv
module mpb_regs
  import mpb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              status_on,
  output logic [CNT_W-1:0]  period_q,
  output logic [CNT_W-1:0]  ontime_q,
  output mpb_cfg_t          cfg_q,
  output logic [DATA_W-1:0] rdata
);
  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      ontime_q <= '0;
      cfg_q    <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PERIOD: period_q <= wdata[CNT_W-1:0];
        A_ONTIME: ontime_q <= wdata[CNT_W-1:0];
        A_CONFIG: cfg_q    <= cfg_unpack(wdata);
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_PERIOD: rdata = DATA_W'(period_q);
      A_ONTIME: rdata = DATA_W'(ontime_q);
      A_CONFIG: rdata = cfg_pack(cfg_q);
      default:  rdata = DATA_W'(status_on);
    endcase
  end
endmodule

// File: rtl/mpb_counter.sv
module mpb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] ontime_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_per,
  output logic [CNT_W-1:0] act_on,
  output logic             wrap,
  output logic             on_phase
);
  assign wrap     = en && (cnt >= act_per);
  assign on_phase = en && (cnt < act_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_per <= '0;
      act_on  <= '0;
    end else if (!en || wrap) begin
      cnt     <= '0;
      act_per <= period_in;
      act_on  <= ontime_in;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mpb_decode.sv
module mpb_decode
  import mpb_pkg::*;
(
  input  mpb_cfg_t cfg,
  input  logic     on_phase,
  output logic     int_h1,
  output logic     int_h2,
  output logic     ext_h1,
  output logic     ext_h2
);
  logic [1:0] legs, swapped, inv_mask, pins;

  assign legs     = phase_legs(cfg, on_phase);
  assign swapped  = cfg.swap ? {legs[0], legs[1]} : legs;
  assign inv_mask = {cfg.inv2, cfg.inv1};

  for (genvar i = 0; i < 2; i++) begin : g_leg
    assign pins[i] = swapped[i] ^ inv_mask[i];
  end

  assign int_h1 = cfg.int_on & pins[0];
  assign int_h2 = cfg.int_on & pins[1];
  assign ext_h1 = cfg.ext_on & pins[0];
  assign ext_h2 = cfg.ext_on & pins[1];
endmodule

// File: rtl/motor_pwm_bridge.sv
module motor_pwm_bridge
  import mpb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        int_h1,
  output logic        int_h2,
  output logic        ext_h1,
  output logic        ext_h2
);
  logic [CNT_W-1:0] period_q, ontime_q, cnt, act_per, act_on;
  logic             wrap, on_phase;
  mpb_cfg_t         cfg_q;

  mpb_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .status_on(on_phase), .period_q(period_q),
    .ontime_q(ontime_q), .cfg_q(cfg_q), .rdata(reg_rdata)
  );

  mpb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .period_in(period_q),
    .ontime_in(ontime_q), .cnt(cnt), .act_per(act_per), .act_on(act_on),
    .wrap(wrap), .on_phase(on_phase)
  );

  mpb_decode u_dec (
    .cfg(cfg_q), .on_phase(on_phase), .int_h1(int_h1), .int_h2(int_h2),
    .ext_h1(ext_h1), .ext_h2(ext_h2)
  );
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker
  import mpb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input mpb_cfg_t         cfg,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_per,
  input logic [CNT_W-1:0] act_on,
  input logic             wrap,
  input logic             on_phase,
  input logic [1:0]       addr,
  input logic [31:0]      rdata,
  input logic             int_h1,
  input logic             int_h2,
  input logic             ext_h1,
  input logic             ext_h2
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.en |-> cnt <= act_per); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cnt >= act_per) |=> cnt == '0); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && $past(cfg.en) && cnt != '0) |-> ($stable(act_on) && $stable(act_per))); // R4
  AST_IDLE_LEGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en && cfg.int_on) |-> (int_h1 == cfg.inv1 && int_h2 == cfg.inv2)); // R8
  AST_INT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.int_on |-> (!int_h1 && !int_h2)); // R11
  AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.ext_on |-> (!ext_h1 && !ext_h2)); // R11
  AST_STATUS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> rdata == {31'b0, on_phase}); // R12
endmodule

bind motor_pwm_bridge mpb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .cnt(cnt), .act_per(act_per),
  .act_on(act_on), .wrap(wrap), .on_phase(on_phase), .addr(reg_addr),
  .rdata(reg_rdata), .int_h1(int_h1), .int_h2(int_h2), .ext_h1(ext_h1),
  .ext_h2(ext_h2)
);

// File: tb/motor_pwm_bridge_bench.sv
module motor_pwm_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        int_h1, int_h2, ext_h1, ext_h2;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] EN = 32'h1, INT = 32'h1_0000, EXT = 32'h2_0000,
    DIRM = 32'h4_0000, FWD = 32'h10_0000, BWD = 32'h20_0000, BRK = 32'h30_0000,
    SWP = 32'h100_0000, DCOAST = 32'h200_0000, INV1 = 32'h400_0000, INV2 = 32'h800_0000;

  always #2.5 clk = ~clk;

  motor_pwm_bridge u_motor_pwm_bridge (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_h1(int_h1),
    .int_h2(int_h2), .ext_h1(ext_h1), .ext_h2(ext_h2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the write done.
  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata; reg_addr = 2'd3; #0.5;
  endtask

  function automatic logic [3:0] pins4();
    return {ext_h2, ext_h1, int_h2, int_h1};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      reg_read(a[1:0], d);
      check("R1 reset readback", d, 32'h0);
    end
    check("R1 reset outputs", {28'b0, pins4()}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    @(negedge clk);
    reg_write(2'd0, 32'hFFFF_1234);
    reg_write(2'd1, 32'hABCD_0042);
    reg_write(2'd2, 32'hFFFF_FFFE);
    reg_write(2'd3, 32'hFFFF_FFFF);
    reg_read(2'd0, d); check("R2 period readback", d, 32'h0000_1234);
    reg_read(2'd1, d); check("R2 on-time readback", d, 32'h0000_0042);
    reg_read(2'd2, d); check("R2 config mask", d, 32'h0F37_0000);
    reg_read(2'd3, d); check("R2 status write ignored", d, 32'h0);
    reg_write(2'd2, 32'h0);
  endtask

  // Run with period p, on-time o from cfg; samples n cycles from count 0.
  task automatic t_wave(input logic [31:0] cfg, input int p, input int o,
                        input logic [1:0] on_legs, input logic [1:0] off_legs,
                        input string req);
    logic on;
    reg_write(2'd0, p);
    reg_write(2'd1, o);
    reg_write(2'd2, cfg);
    for (int k = 0; k < 2 * (p + 1); k++) begin
      on = (k % (p + 1)) < o;
      #0.5;
      check({req, " R3 R12 status"}, reg_rdata, {31'b0, on});
      check({req, " legs"}, {30'b0, int_h2, int_h1}, {30'b0, on ? on_legs : off_legs});
      @(negedge clk);
    end
    reg_write(2'd2, 32'h0);
  endtask

  task automatic t_shadow();
    logic exp_on[$];
    reg_write(2'd0, 32'd4);
    reg_write(2'd1, 32'd2);
    reg_write(2'd2, EN | INT | FWD);
    // counts 0,1,2 sampled before the write, old on-time 2
    for (int k = 0; k < 3; k++) begin
      #0.5; check("R4 before update", reg_rdata, {31'b0, k < 2});
      if (k < 2) @(negedge clk);
    end
    reg_write(2'd1, 32'd4);
    // counts 3,4 keep old value; 0..3 on and 4 off with new value
    exp_on = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    foreach (exp_on[i]) begin
      #0.5; check("R4 deferred on-time", reg_rdata, {31'b0, exp_on[i]});
      @(negedge clk);
    end
    reg_write(2'd2, 32'h0);
  endtask

  task automatic t_static(input logic [31:0] cfg, input logic [3:0] exp, input string req);
    reg_write(2'd2, cfg);
    #0.5;
    check(req, {28'b0, pins4()}, {28'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_regmap();
    t_wave(EN | INT | FWD, 4, 2, 2'b01, 2'b11, "R6 brake dwell R5 forward");
    t_wave(EN | INT | BWD | DCOAST, 3, 1, 2'b10, 2'b00, "R6 coast dwell R5 backward");
    t_shadow();
    reg_write(2'd0, 32'd5);
    reg_write(2'd1, 32'd0);
    t_static(EN | INT | DIRM,             4'b0000, "R7 R5 coast");
    t_static(EN | INT | DIRM | FWD,       4'b0001, "R7 R5 forward");
    t_static(EN | INT | DIRM | BWD,       4'b0010, "R7 R5 backward");
    t_static(EN | INT | DIRM | BRK,       4'b0011, "R7 R5 brake");
    t_static(EN | INT | DIRM | FWD | SWP, 4'b0010, "R9 swap");
    t_static(EN | INT | DIRM | FWD | SWP | INV1, 4'b0011, "R10 invert out1 after swap");
    t_static(EN | INT | DIRM | BWD | INV2, 4'b0000, "R10 invert out2");
    t_static(INT | DIRM | BRK,            4'b0000, "R8 disabled coast");
    t_static(INT | DIRM | BRK | INV1,     4'b0001, "R8 disabled with invert");
    t_static(EN | EXT | DIRM | FWD,       4'b0100, "R11 external only");
    t_static(EN | INT | EXT | DIRM | BWD, 4'b1010, "R11 both bridges");
    t_static(EN | DIRM | BRK,             4'b0000, "R11 no bridge");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule